// File: doc/BRIEF.md
# Serial Flash Receive Ring Buffer

This block holds the data words that a serial flash read engine fetches and hands them to a host. The engine side is a valid/ready word stream with a byte-count start command. The host side has one fixed pop view that always shows the oldest unread word. It also has a drain strobe, a DMA request/acknowledge pair, and an indexed view that reads any storage slot directly.

The ring holds 15 words of 32 bits each. Two read and write indices wrap modulo 15, and an occupancy counter tells a full ring from an empty one. The ring never back-pressures a running transfer. `wr_ready` follows `xfer_busy`, so while a transfer runs every offered word is taken. A word that arrives when the ring is full is dropped. It raises the sticky overrun flag and ends the transfer, which tells the engine to stop. A transfer also ends normally once the word carrying its last requested byte has been accepted. Words offered while no transfer is running are not taken.

Reading the pop view never moves the read index. In flag mode only the drain strobe moves it. In DMA mode only the acknowledge moves it.

Top module: `sflash_rx_ring`

## Requirements
- R1: After reset the ring is empty (`not_empty`=0), `overrun`=0, `xfer_busy`=0, `wr_ready`=0, `eng_stop`=0, `dma_req`=0 and `irq`=0.
- R2: `pop_data` shows the oldest unread word, in arrival order. It keeps showing that word until the read index advances, however long it is observed.
- R3: With `dma_en`=0, each `drain_wr` cycle advances the read index by one. `dma_ack` has no effect. A `drain_wr` on an empty ring changes nothing.
- R4: With `dma_en`=1, each `dma_ack` cycle advances the read index by one and `drain_wr` has no effect. `dma_req` is high exactly when `dma_en` is 1 and the ring is not empty, so it falls in the cycle after the acknowledge that takes the last word.
- R5: `not_empty` is 1 in every cycle where at least one accepted word is unread.
- R6: A word offered during a transfer while 15 words are unread is dropped. In the next cycle `overrun`=1, `eng_stop`=1 for one cycle, and `xfer_busy`=`wr_ready`=0.
- R7: A transfer started with N bytes (N>0) ends after ceil(N/4) words are accepted. In the cycle after that word, `eng_stop` is 1 for exactly one cycle and `xfer_busy` is 0.
- R8: `overrun` stays set until a cycle with `ovf_clr`=1. If a new overrun happens in the same cycle as the clear, the flag stays set.
- R9: `idx_data` returns the content of slot `idx_sel` (0 to 14) whatever the indices hold. For `idx_sel` of 15 it returns 0.
- R10: The write and read indices wrap from slot 14 to slot 0. Word k of a run that begins at write index w lands in slot (w+k) mod 15.
- R11: `irq` = (`not_empty` AND `ie_ne`) OR (`overrun` AND `ie_ovf`).
- R12: A `xfer_start` while a transfer is running, or one with `xfer_bytes`=0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start a transfer of `xfer_bytes` bytes |
| xfer_bytes | input | 16 | Requested byte count |
| xfer_busy | output | 1 | Transfer running |
| eng_stop | output | 1 | One-cycle stop request to the serial engine |
| wr_valid | input | 1 | Engine offers a word |
| wr_ready | output | 1 | Ring takes offered words |
| wr_data | input | 32 | Received word |
| pop_data | output | 32 | Word at the read index |
| drain_wr | input | 1 | Host write of 1 to the drain flag |
| dma_en | input | 1 | Selects DMA advance mode |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA has read `pop_data` |
| idx_sel | input | 4 | Slot index for direct read |
| idx_data | output | 32 | Slot content |
| not_empty | output | 1 | Unread data present |
| overrun | output | 1 | Sticky overrun flag |
| ovf_clr | input | 1 | Write-1-to-clear for `overrun` |
| ie_ne | input | 1 | Interrupt enable, not-empty |
| ie_ovf | input | 1 | Interrupt enable, overrun |
| irq | output | 1 | Interrupt |

## Verification
The ring is filled by three kinds of transfer. A short transfer ends on an exact word count. A transfer with a byte count that is not a multiple of four shows whether the last partial word is counted as a word. A long transfer runs into overrun after the ring wraps, and this shows whether the drop check uses the occupancy or the indices. Draining is tried in flag mode and in DMA mode, each time with the other mode's strobe also pulsed. This shows whether the advance source is selected by mode or simply ORed. The indexed reads after the wrap show whether slot addressing follows the modulo-15 index and not the arrival count.

// File: rtl/sfrx_pkg.sv
package sfrx_pkg;

  typedef enum logic [1:0] {
    END_NONE    = 2'd0,
    END_COUNT   = 2'd1,
    END_OVERRUN = 2'd2
  } sfrx_end_e;

  // Increment with wrap at a non-power-of-two depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sfrx_store.sv
module sfrx_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 15,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PTR_W-1:0]  idx_sel,
  output logic [DATA_W-1:0] idx_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (push && (wr_ptr == PTR_W'(g))) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data  = '0;
    idx_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr  == PTR_W'(i)) rd_data  = slot_q[i];
      if (idx_sel == PTR_W'(i)) idx_data = slot_q[i];
    end
  end

endmodule

// File: rtl/sfrx_occupancy.sv
module sfrx_occupancy #(
  parameter int DEPTH = 15,
  parameter int PTR_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop_req,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             not_empty
);

  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             pop;

  assign not_empty = (count_q != '0);
  assign full      = (count_q == CNT_W'(DEPTH));
  assign pop       = pop_req && not_empty;
  assign wr_ptr    = wr_q;
  assign rd_ptr    = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_q <= PTR_W'(sfrx_pkg::wrap_inc(int'(wr_q), DEPTH));
      if (pop)  rd_q <= PTR_W'(sfrx_pkg::wrap_inc(int'(rd_q), DEPTH));
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/sfrx_xfer_ctl.sv
module sfrx_xfer_ctl #(
  parameter int BYTES_W        = 16,
  parameter int BYTES_PER_WORD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               wr_valid,
  input  logic               full,
  input  logic               ovf_clr,
  output logic               busy,
  output logic               push,
  output logic               stop,
  output logic               ovf_flag
);

  logic [BYTES_W-1:0]  remain_q;
  logic                busy_q, stop_q, ovf_q;
  logic                take;
  sfrx_pkg::sfrx_end_e end_cause;

  assign take = wr_valid && busy_q;
  assign push = take && !full;

  always_comb begin
    end_cause = sfrx_pkg::END_NONE;
    if (take && full) end_cause = sfrx_pkg::END_OVERRUN;
    else if (push && (remain_q <= BYTES_W'(BYTES_PER_WORD))) end_cause = sfrx_pkg::END_COUNT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      busy_q   <= 1'b0;
      stop_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      stop_q <= (end_cause != sfrx_pkg::END_NONE);
      if (!busy_q) begin
        if (start && (bytes != '0)) begin
          busy_q   <= 1'b1;
          remain_q <= bytes;
        end
      end else if (end_cause != sfrx_pkg::END_NONE) begin
        busy_q   <= 1'b0;
        remain_q <= '0;
      end else if (push) begin
        remain_q <= remain_q - BYTES_W'(BYTES_PER_WORD);
      end
      if (end_cause == sfrx_pkg::END_OVERRUN) ovf_q <= 1'b1;
      else if (ovf_clr)                       ovf_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign stop     = stop_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/sflash_rx_ring.sv
module sflash_rx_ring #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 15,
  parameter int BYTES_W = 16,
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BPW    = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start,
  input  logic [BYTES_W-1:0] xfer_bytes,
  output logic               xfer_busy,
  output logic               eng_stop,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  pop_data,
  input  logic               drain_wr,
  input  logic               dma_en,
  output logic               dma_req,
  input  logic               dma_ack,
  input  logic [PTR_W-1:0]   idx_sel,
  output logic [DATA_W-1:0]  idx_data,
  output logic               not_empty,
  output logic               overrun,
  input  logic               ovf_clr,
  input  logic               ie_ne,
  input  logic               ie_ovf,
  output logic               irq
);

  logic             push, full, advance;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // One advance source per mode; the other strobe is ignored.
  assign advance = dma_en ? dma_ack : drain_wr;

  sfrx_xfer_ctl #(.BYTES_W(BYTES_W), .BYTES_PER_WORD(BPW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .bytes(xfer_bytes),
    .wr_valid(wr_valid), .full(full), .ovf_clr(ovf_clr),
    .busy(xfer_busy), .push(push), .stop(eng_stop), .ovf_flag(overrun)
  );

  sfrx_occupancy #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .push(push), .pop_req(advance),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .not_empty(not_empty)
  );

  sfrx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(pop_data), .idx_sel(idx_sel), .idx_data(idx_data)
  );

  assign wr_ready = xfer_busy;
  assign dma_req  = dma_en && not_empty;
  assign irq      = (not_empty && ie_ne) || (overrun && ie_ovf);

endmodule

// File: rtl/sflash_rx_ring_chk.sv
module sflash_rx_ring_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_busy,
  input logic eng_stop,
  input logic wr_valid,
  input logic wr_ready,
  input logic not_empty,
  input logic overrun,
  input logic ovf_clr,
  input logic dma_req,
  input logic ie_ne,
  input logic ie_ovf,
  input logic irq
);

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |-> !xfer_busy);

  p_stop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |=> !eng_stop);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovf_clr) |=> overrun);

  p_ovf_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (eng_stop && !wr_ready));

  p_req_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> not_empty);

  p_empty_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && !(wr_valid && wr_ready)) |=> !not_empty);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_ne && !ie_ovf) |-> !irq);

endmodule

bind sflash_rx_ring sflash_rx_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .eng_stop(eng_stop),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .not_empty(not_empty),
  .overrun(overrun), .ovf_clr(ovf_clr), .dma_req(dma_req),
  .ie_ne(ie_ne), .ie_ovf(ie_ovf), .irq(irq)
);

// File: tb/test_sflash_rx_ring.sv
module test_sflash_rx_ring;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0;
  logic [15:0] xfer_bytes = '0;
  logic        xfer_busy, eng_stop, wr_ready, dma_req, not_empty, overrun, irq;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] pop_data, idx_data;
  logic        drain_wr = 1'b0, dma_en = 1'b0, dma_ack = 1'b0;
  logic [3:0]  idx_sel = '0;
  logic        ovf_clr = 1'b0, ie_ne = 1'b0, ie_ovf = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  logic [31:0] burst [15];

  always #4 clk = ~clk;

  sflash_rx_ring i_sflash_rx_ring (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_bytes(xfer_bytes),
    .xfer_busy(xfer_busy), .eng_stop(eng_stop), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .pop_data(pop_data),
    .drain_wr(drain_wr), .dma_en(dma_en), .dma_req(dma_req), .dma_ack(dma_ack),
    .idx_sel(idx_sel), .idx_data(idx_data), .not_empty(not_empty),
    .overrun(overrun), .ovf_clr(ovf_clr), .ie_ne(ie_ne), .ie_ovf(ie_ovf), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start_xfer(input logic [15:0] n);
    xfer_start = 1'b1; xfer_bytes = n;
    tick();
    xfer_start = 1'b0;
  endtask

  // Driver: offers one word; pushes it into the scoreboard when it should be kept.
  task automatic send_word(input logic [31:0] d, input bit keep);
    wr_valid = 1'b1; wr_data = d;
    if (keep) exp_q.push_back(d);
    tick();
    wr_valid = 1'b0;
  endtask

  // Monitor: compares the pop view with the scoreboard head, then advances.
  task automatic take_word(input bit use_dma, input string req);
    logic [31:0] e;
    e = exp_q.pop_front();
    #1;
    chk(pop_data == e, req, pop_data, e);
    if (use_dma) dma_ack = 1'b1; else drain_wr = 1'b1;
    tick();
    dma_ack = 1'b0; drain_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk({not_empty, overrun, xfer_busy, wr_ready, eng_stop, dma_req, irq} == 7'b0,
        "R1", {25'b0, not_empty, overrun, xfer_busy, wr_ready, eng_stop, dma_req, irq}, 0);

    // Word offered with no transfer running is not taken (R5 stays low)
    send_word(32'hDEAD0000, 1'b0);
    chk(!not_empty, "R5 idle word", not_empty, 0);

    // R7: 12 bytes -> 3 words
    start_xfer(16'd12);
    chk(xfer_busy && wr_ready, "R7 busy", xfer_busy, 1);
    send_word(32'hA0000001, 1'b1);
    send_word(32'hA0000002, 1'b1);
    chk(!eng_stop && xfer_busy, "R7 mid", eng_stop, 0);
    send_word(32'hA0000003, 1'b1);
    chk(eng_stop && !xfer_busy && !wr_ready, "R7 end", eng_stop, 1);
    tick();
    chk(!eng_stop, "R7 pulse", eng_stop, 0);
    chk(not_empty, "R5", not_empty, 1);

    // R2: repeated observation does not advance
    hold = pop_data;
    tick(); tick();
    chk(pop_data == hold && hold == 32'hA0000001, "R2 hold", pop_data, 32'hA0000001);

    // R9 indexed reads
    idx_sel = 4'd1; #1;
    chk(idx_data == 32'hA0000002, "R9 slot1", idx_data, 32'hA0000002);
    idx_sel = 4'd15; #1;
    chk(idx_data == 32'h0, "R9 slot15", idx_data, 0);

    // R11 not-empty interrupt
    ie_ne = 1'b1; #1;
    chk(irq, "R11 ne", irq, 1);
    ie_ne = 1'b0; #1;
    chk(!irq, "R11 masked", irq, 0);

    // R3: dma_ack ignored in flag mode
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    chk(pop_data == 32'hA0000001, "R3 ack ignored", pop_data, 32'hA0000001);
    take_word(1'b0, "R3 drain");
    take_word(1'b0, "R3 drain");
    take_word(1'b0, "R3 drain");
    chk(!not_empty, "R5 empty", not_empty, 0);
    drain_wr = 1'b1; tick(); drain_wr = 1'b0;
    chk(!not_empty, "R3 empty drain", not_empty, 0);

    // R6 + R10: 80 bytes; ring fills after wrap (indices start at 3)
    start_xfer(16'd80);
    for (int k = 0; k < 15; k++) begin
      burst[k] = 32'hB0000000 + k;
      send_word(burst[k], 1'b1);
    end
    chk(xfer_busy && !overrun, "R6 full no ovf", overrun, 0);
    send_word(32'hBADBAD00, 1'b0);
    chk(overrun && eng_stop && !xfer_busy && !wr_ready, "R6 overrun", overrun, 1);
    idx_sel = 4'd0; #1;
    chk(idx_data == burst[12], "R10 wrap slot0", idx_data, burst[12]);
    idx_sel = 4'd3; #1;
    chk(idx_data == burst[0], "R10 slot3", idx_data, burst[0]);

    // R11 overrun interrupt, R8 sticky then clear
    ie_ovf = 1'b1; #1;
    chk(irq, "R11 ovf", irq, 1);
    tick(); tick();
    chk(overrun, "R8 sticky", overrun, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    chk(!overrun && !irq, "R8 clear", overrun, 0);
    ie_ovf = 1'b0;

    // R4 DMA drain; drain_wr ignored in DMA mode
    dma_en = 1'b1; #1;
    chk(dma_req, "R4 req", dma_req, 1);
    drain_wr = 1'b1; tick(); drain_wr = 1'b0;
    chk(pop_data == burst[0], "R4 drain ignored", pop_data, burst[0]);
    for (int k = 0; k < 15; k++) take_word(1'b1, "R4 dma data");
    chk(!dma_req && !not_empty, "R4 req drop", dma_req, 0);
    dma_en = 1'b0;

    // R12: start during busy ignored; 6 bytes -> 2 words
    start_xfer(16'd6);
    start_xfer(16'd100);
    send_word(32'hC0000001, 1'b1);
    send_word(32'hC0000002, 1'b1);
    chk(eng_stop && !xfer_busy, "R12 restart ignored", xfer_busy, 0);
    start_xfer(16'd0);
    chk(!xfer_busy, "R12 zero bytes", xfer_busy, 0);
    take_word(1'b0, "R2 order");
    take_word(1'b0, "R2 order");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule